// File: doc/BRIEF.md
# Set/Clear GPIO Register Bank

A bank of general-purpose pins controlled over a simple register bus. Software never rewrites a whole output word: it changes output level and driver enable through four action offsets. Each action touches only the pins whose data bits are one, so separate agents can steer separate pins with no read-modify-write. The bit at data position n always belongs to pin n, in a 32-bit little-endian word.

Pin levels come back through a two-flop synchronizer and a read-only input offset. The action offsets are write-only. Any access to an offset outside the map has no effect.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset, pad_out and pad_oe are all zero (every pin driven low in value and tristated), and rdata is zero.
- R2: A write to offset 0x00 sets each pad_out bit whose wdata bit is one, from the cycle after the write.
- R3: A write to offset 0x10 clears each pad_out bit whose wdata bit is one, from the cycle after the write.
- R4: A write to offset 0x20 sets each pad_oe bit (driver on) whose wdata bit is one, from the cycle after the write.
- R5: A write to offset 0x30 clears each pad_oe bit (pin tristated) whose wdata bit is one, from the cycle after the write.
- R6: In every action write, pins whose wdata bit is zero keep both their pad_out and pad_oe values.
- R7: A read of offset 0x40 returns the synchronized pad_in word on rdata in the cycle after rd_en. Bit n is pin n. A pad_in change first shows for a read whose rd_en is sampled on the third rising edge after the change, and never on the second.
- R8: Reads of offsets 0x00, 0x10, 0x20, 0x30 and of unmapped offsets return zero. rdata is zero in any cycle that does not follow a read.
- R9: Writes to offset 0x40 or to unmapped offsets, including unaligned ones such as 0x04, change neither pad_out nor pad_oe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 8 | Byte offset |
| wdata | input | 32 | Write data, bit n for pin n |
| rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Pin input levels, asynchronous |
| pad_out | output | 32 | Pin output values |
| pad_oe | output | 32 | Pin driver enables |

## Verification
Action writes take effect one cycle after the strobe. The bench drives each write on a falling edge and checks pad_out and pad_oe on the next falling edge, against a model updated from the requirements. Read data is checked one falling edge after rd_en. A pad_in change is held through two rising edges before the read strobe is sampled. One directed read is made a cycle early, and it must still show the old level. Random writes, reads and pin changes from a fixed seed run between the directed cases.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int OFS_LVL_SET = 'h00;
    localparam int OFS_LVL_CLR = 'h10;
    localparam int OFS_DRV_ON  = 'h20;
    localparam int OFS_DRV_OFF = 'h30;
    localparam int OFS_PIN_RD  = 'h40;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_LVL_SET,
        ACT_LVL_CLR,
        ACT_DRV_ON,
        ACT_DRV_OFF,
        ACT_PIN_RD
    } gpio_act_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_bank_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_act_e         act
);
    always_comb begin
        act = ACT_NONE;
        if (addr == ADDR_W'(OFS_LVL_SET))      act = ACT_LVL_SET;
        else if (addr == ADDR_W'(OFS_LVL_CLR)) act = ACT_LVL_CLR;
        else if (addr == ADDR_W'(OFS_DRV_ON))  act = ACT_DRV_ON;
        else if (addr == ADDR_W'(OFS_DRV_OFF)) act = ACT_DRV_OFF;
        else if (addr == ADDR_W'(OFS_PIN_RD))  act = ACT_PIN_RD;
    end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int PIN_N  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_N-1:0] raw,
    output logic [PIN_N-1:0] synced
);
    logic [PIN_N-1:0] stg_d [STAGES];
    logic [PIN_N-1:0] stg_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_comb stg_d[s] = raw;
        end else begin : g_next
            always_comb stg_d[s] = stg_q[s-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_d[s];
        end
    end

    assign synced = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_pin_regs.sv
module gpio_pin_regs
    import gpio_bank_pkg::*;
#(
    parameter int PIN_N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  gpio_act_e        act,
    input  logic [PIN_N-1:0] wdata,
    output logic [PIN_N-1:0] lvl,
    output logic [PIN_N-1:0] drv
);
    typedef struct packed {
        logic [PIN_N-1:0] lvl;
        logic [PIN_N-1:0] drv;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (act)
                ACT_LVL_SET: st_d.lvl = st_q.lvl | wdata;
                ACT_LVL_CLR: st_d.lvl = st_q.lvl & ~wdata;
                ACT_DRV_ON:  st_d.drv = st_q.drv | wdata;
                ACT_DRV_OFF: st_d.drv = st_q.drv & ~wdata;
                default:     st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl = st_q.lvl;
    assign drv = st_q.drv;

    a_r2_set_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && act == ACT_LVL_SET) |=> ((lvl & $past(wdata)) == $past(wdata)));
    a_r3_clr_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && act == ACT_LVL_CLR) |=> ((lvl & $past(wdata)) == '0));
    a_r4_drv_on: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && act == ACT_DRV_ON) |=> ((drv & $past(wdata)) == $past(wdata)));
    a_r5_drv_off: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && act == ACT_DRV_OFF) |=> ((drv & $past(wdata)) == '0));
    a_r6_zero_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (((lvl ^ $past(lvl)) & ~$past(wdata)) == '0)
               && (((drv ^ $past(drv)) & ~$past(wdata)) == '0));
    a_r9_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (act == ACT_NONE || act == ACT_PIN_RD)) |=> ($stable(lvl) && $stable(drv)));
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
    import gpio_bank_pkg::*;
#(
    parameter int PIN_N = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  gpio_act_e        act,
    input  logic [PIN_N-1:0] pin_lvl,
    output logic [PIN_N-1:0] rdata
);
    logic [PIN_N-1:0] rdata_d, rdata_q;

    always_comb begin
        rdata_d = '0;
        if (rd_en && act == ACT_PIN_RD) rdata_d = pin_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    a_r7_pin_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && act == ACT_PIN_RD) |=> (rdata == $past(pin_lvl)));
    a_r8_other_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && act == ACT_PIN_RD) |=> (rdata == '0));
endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
    import gpio_bank_pkg::*;
#(
    parameter int PIN_N       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PIN_N-1:0]  wdata,
    output logic [PIN_N-1:0]  rdata,
    input  logic [PIN_N-1:0]  pad_in,
    output logic [PIN_N-1:0]  pad_out,
    output logic [PIN_N-1:0]  pad_oe
);
    gpio_act_e        act;
    logic [PIN_N-1:0] pin_sync;

    gpio_addr_dec #(.ADDR_W(ADDR_W)) i_dec (
        .addr (addr),
        .act  (act)
    );

    gpio_in_sync #(.PIN_N(PIN_N), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pad_in),
        .synced (pin_sync)
    );

    gpio_pin_regs #(.PIN_N(PIN_N)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .act   (act),
        .wdata (wdata),
        .lvl   (pad_out),
        .drv   (pad_oe)
    );

    gpio_rd_path #(.PIN_N(PIN_N)) i_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .act     (act),
        .pin_lvl (pin_sync),
        .rdata   (rdata)
    );
endmodule

// File: tb/test_gpio_setclr_bank.sv
module test_gpio_setclr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [31:0] m_out = '0;
    logic [31:0] m_oe = '0;

    always #4 clk = ~clk;

    gpio_setclr_bank i_gpio_setclr_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(string req, logic [31:0] act_v, logic [31:0] exp_v);
        n_run++;
        if (act_v !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act_v, exp_v);
        end
    endtask

    function automatic string req_of(logic [7:0] a);
        case (a)
            8'h00: return "R2";
            8'h10: return "R3";
            8'h20: return "R4";
            8'h30: return "R5";
            default: return "R9";
        endcase
    endfunction

    // model of an action write (R2..R6, R9)
    task automatic model_write(logic [7:0] a, logic [31:0] d);
        case (a)
            8'h00: m_out = m_out | d;
            8'h10: m_out = m_out & ~d;
            8'h20: m_oe  = m_oe | d;
            8'h30: m_oe  = m_oe & ~d;
            default: ;
        endcase
    endtask

    task automatic do_write(logic [7:0] a, logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
        check({req_of(a), "/R6 pad_out"}, pad_out, m_out);
        check({req_of(a), "/R6 pad_oe"}, pad_oe, m_oe);
    endtask

    task automatic do_read(logic [7:0] a, output logic [31:0] v);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin
        logic [31:0] v;
        logic [7:0]  offs [8] = '{8'h00, 8'h10, 8'h20, 8'h30, 8'h40, 8'h04, 8'h50, 8'hFF};
        void'($urandom(32'd7041));
        repeat (3) @(negedge clk);
        check("R1 pad_out", pad_out, 32'h0);
        check("R1 pad_oe", pad_oe, 32'h0);
        check("R1 rdata", rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed action writes, including all-ones and all-zeros data
        do_write(8'h00, 32'hA5A5_0F0F);
        do_write(8'h00, 32'h0000_0000);
        do_write(8'h10, 32'h0000_000F);
        do_write(8'h20, 32'hFFFF_FFFF);
        do_write(8'h30, 32'h8000_0001);
        do_write(8'h10, 32'hFFFF_FFFF);
        do_write(8'h00, 32'h0000_0001); // bit 0 is pin 0 (R2)
        // writes with no effect (R9)
        do_write(8'h40, 32'hFFFF_FFFF);
        do_write(8'h04, 32'hFFFF_FFFF);
        do_write(8'h31, 32'hFFFF_FFFF);
        check("R8 idle rdata", rdata, 32'h0);

        // synchronizer latency (R7)
        pad_in = 32'h1234_5678;
        repeat (2) @(negedge clk);
        do_read(8'h40, v);
        check("R7 pin read", v, 32'h1234_5678);
        pad_in = 32'hCAFE_0001;
        @(negedge clk);
        do_read(8'h40, v);
        check("R7 early read keeps old level", v, 32'h1234_5678);
        @(negedge clk);
        do_read(8'h40, v);
        check("R7 pin read after sync", v, 32'hCAFE_0001);
        @(negedge clk);
        check("R8 rdata after read", rdata, 32'h0);

        // write-only and unmapped reads (R8)
        for (int i = 0; i < 8; i++) begin
            if (offs[i] != 8'h40) begin
                do_read(offs[i], v);
                check("R8 non-pin read", v, 32'h0);
            end
        end

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 2);
            if (op == 0) begin
                logic [31:0] p = $urandom();
                pad_in = p;
                repeat (2) @(negedge clk);
                do_read(8'h40, v);
                check("R7 random pin read", v, p);
            end else if (op == 1) begin
                logic [7:0] a = offs[$urandom_range(0, 7)];
                do_read(a, v);
                check(a == 8'h40 ? "R7 random read" : "R8 random read", v,
                      a == 8'h40 ? pad_in : 32'h0);
            end else begin
                do_write(offs[$urandom_range(0, 7)], $urandom());
            end
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule